// File: doc/BRIEF.md
# Transmit Line Capture with Alarm-Driven All-Ones Override

This block takes the transmit line input of a 140 Mbit/s mapper. It captures parallel line data, either a full byte or a half-byte (nibble) at a time, and forms complete bytes from it. Each capture happens on one edge of the line clock, and a software control selects the rising edge or the falling edge. The line clock is sampled by the faster system clock, so both edges are detected in one clock domain. Each complete byte is then emitted either unchanged or replaced with all ones. The all-ones pattern is the alarm indication signal (AIS).

The AIS decision is an OR of four terms. One is a software force bit, which wins regardless of anything else. The other three are alarm flags: external loss of signal, loss of transmit clock and loss of frame alignment. Each flag counts only when its own enable is set. The decision is registered and applied one whole byte at a time, so a switch never splits a byte. Each emitted byte comes with an AIS-active status and a vector that shows which terms caused it.

Top module: `tlc_tx_capture`

## Requirements
- R1: With `cap_on_fall_i` = 0, a capture happens only on a 0-to-1 transition of `line_clk_i` as seen by `clk`. A 1-to-0 transition captures nothing.
- R2: With `cap_on_fall_i` = 1, a capture happens only on a 1-to-0 transition of `line_clk_i`. A 0-to-1 transition captures nothing.
- R3: In byte mode, each capture emits one byte. `word_valid_o` is high for exactly one cycle, starting at the clock edge that detects the line edge, and `word_o` carries `line_data_i` as sampled at that edge.
- R4: In nibble mode, two captures form one byte. The first capture supplies bits 7:4 and the second supplies bits 3:0, both taken from `line_data_i[3:0]`. `line_data_i[7:4]` is ignored, and the first capture emits nothing.
- R5: `nibble_mode_i` (1 = nibble, 0 = byte) is sampled only while `rst_n` is low. Changing it after reset has no effect on how bytes are assembled.
- R6: When `force_ais_i` is 1, the emitted byte is 8'hFF and `ais_o` is 1, whatever the alarm flags and enables are.
- R7: Alarm bit 0 (external loss of signal) causes AIS when `alarm_i[0]` and `alarm_en_i[0]` are both 1.
- R8: Alarm bit 1 (loss of transmit clock) causes AIS when `alarm_i[1]` and `alarm_en_i[1]` are both 1.
- R9: Alarm bit 2 (loss of frame alignment) causes AIS when `alarm_i[2]` and `alarm_en_i[2]` are both 1. A flag whose enable is 0 has no effect.
- R10: The AIS decision is registered. A byte emitted at clock edge k uses the force, flag and enable values sampled at edge k-1. `ais_o` and `ais_cause_o` change only when a byte is emitted.
- R11: `ais_cause_o` is captured along with each byte. Bit 0 is the force bit, and bit k+1 is `alarm_i[k] & alarm_en_i[k]`. `ais_o` equals the OR of `ais_cause_o`.
- R12: While `rst_n` is low at a clock edge, `word_valid_o`, `word_o`, `ais_o` and `ais_cause_o` become 0 and any half-assembled byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nibble_mode_i | input | 1 | 1 = nibble lanes, 0 = byte lanes; sampled in reset |
| cap_on_fall_i | input | 1 | 0 = capture on line clock rise, 1 = on fall |
| line_clk_i | input | 1 | Transmit line clock |
| line_data_i | input | 8 | Transmit line data |
| force_ais_i | input | 1 | Software AIS force |
| alarm_i | input | 3 | Alarm flags: bit0 loss of signal, bit1 loss of clock, bit2 loss of frame |
| alarm_en_i | input | 3 | Per-flag enables, same bit order |
| word_o | output | 8 | Emitted byte |
| word_valid_o | output | 1 | One-cycle strobe per emitted byte |
| ais_o | output | 1 | AIS was applied to the last emitted byte |
| ais_cause_o | output | 4 | Terms that caused AIS on the last byte |

## Verification
For each of the four combinations of lane mode and capture edge, the bench steps through all 128 combinations of force bit, three flags and three enables. Each emitted byte is checked against the value computed from the gated OR, which tells each enable's masking apart from the force's override. Every capture is followed by the opposite line-clock edge carrying inverted data, and that edge must emit nothing, which separates the two edge polarities. Nibble captures carry junk in the upper data bits and the mode pin is flipped after reset, which shows whether the lanes are built correctly and whether the mode is latched only in reset. A final step clears every alarm between bytes and confirms that the status holds until the next byte is emitted.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic {
        LANE_BYTE   = 1'b0,
        LANE_NIBBLE = 1'b1
    } lane_mode_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } cap_edge_e;

endpackage

// File: rtl/tlc_edge_pick.sv
module tlc_edge_pick
    import tlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_on_fall_i,
    input  logic line_clk_i,
    output logic cap_o
);

    typedef struct packed {
        logic lclk;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise, fall;
    cap_edge_e sel;

    always_comb begin
        sel   = cap_edge_e'(cap_on_fall_i);
        rise  = line_clk_i & ~st_q.lclk;
        fall  = ~line_clk_i & st_q.lclk;
        cap_o = (sel == EDGE_FALL) ? fall : rise;
        st_d.lclk = line_clk_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tlc_word_pack.sv
module tlc_word_pack
    import tlc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nibble_mode_i,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_stb_o
);

    localparam int NIB_W = DATA_W / 2;

    typedef struct packed {
        lane_mode_e       mode;
        logic             upper_held;
        logic [NIB_W-1:0] hold;
    } pack_st_t;

    pack_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        word_o     = data_i;
        word_stb_o = 1'b0;
        if (cap_i) begin
            if (st_q.mode == LANE_BYTE) begin
                word_stb_o = 1'b1;
            end else if (!st_q.upper_held) begin
                st_d.hold       = data_i[NIB_W-1:0];
                st_d.upper_held = 1'b1;
            end else begin
                word_o          = {st_q.hold, data_i[NIB_W-1:0]};
                word_stb_o      = 1'b1;
                st_d.upper_held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode       <= lane_mode_e'(nibble_mode_i);
            st_q.upper_held <= 1'b0;
            st_q.hold       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlc_ais_ctrl.sv
module tlc_ais_ctrl #(
    parameter int N_ALARM = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               force_i,
    input  logic [N_ALARM-1:0] alarm_i,
    input  logic [N_ALARM-1:0] alarm_en_i,
    output logic [N_ALARM:0]   cause_o
);

    logic [N_ALARM-1:0] gated;
    logic [N_ALARM:0]   cause_d, cause_q;

    for (genvar k = 0; k < N_ALARM; k++) begin : g_gate
        assign gated[k] = alarm_i[k] & alarm_en_i[k];
    end

    always_comb begin
        cause_d = {gated, force_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/tlc_tx_capture.sv
module tlc_tx_capture
    import tlc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_ALARM = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nibble_mode_i,
    input  logic               cap_on_fall_i,
    input  logic               line_clk_i,
    input  logic [DATA_W-1:0]  line_data_i,
    input  logic               force_ais_i,
    input  logic [N_ALARM-1:0] alarm_i,
    input  logic [N_ALARM-1:0] alarm_en_i,
    output logic [DATA_W-1:0]  word_o,
    output logic               word_valid_o,
    output logic               ais_o,
    output logic [N_ALARM:0]   ais_cause_o
);

    localparam int CAUSE_W = N_ALARM + 1;

    typedef struct packed {
        logic [DATA_W-1:0]  word;
        logic               valid;
        logic               ais;
        logic [CAUSE_W-1:0] cause;
    } out_st_t;

    logic               cap;
    logic [DATA_W-1:0]  packed_word;
    logic               packed_stb;
    logic [CAUSE_W-1:0] req_cause;
    out_st_t            st_d, st_q;

    tlc_edge_pick u_edge (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_on_fall_i (cap_on_fall_i),
        .line_clk_i    (line_clk_i),
        .cap_o         (cap)
    );

    tlc_word_pack #(.DATA_W(DATA_W)) u_pack (
        .clk           (clk),
        .rst_n         (rst_n),
        .nibble_mode_i (nibble_mode_i),
        .cap_i         (cap),
        .data_i        (line_data_i),
        .word_o        (packed_word),
        .word_stb_o    (packed_stb)
    );

    tlc_ais_ctrl #(.N_ALARM(N_ALARM)) u_ais (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_i    (force_ais_i),
        .alarm_i    (alarm_i),
        .alarm_en_i (alarm_en_i),
        .cause_o    (req_cause)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = packed_stb;
        if (packed_stb) begin
            st_d.cause = req_cause;
            st_d.ais   = |req_cause;
            st_d.word  = (|req_cause) ? {DATA_W{1'b1}} : packed_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o       = st_q.word;
    assign word_valid_o = st_q.valid;
    assign ais_o        = st_q.ais;
    assign ais_cause_o  = st_q.cause;

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
    parameter int DATA_W  = 8,
    parameter int N_ALARM = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] word_o,
    input logic              word_valid_o,
    input logic              ais_o,
    input logic [N_ALARM:0]  ais_cause_o
);

    p_rst_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (!word_valid_o && !ais_o && ais_cause_o == '0 && word_o == '0));

    p_allones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && ais_o) |-> (word_o == {DATA_W{1'b1}}));

    p_cause_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (ais_o == (ais_cause_o != '0)));

    p_hold_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> ($stable(ais_o) && $stable(ais_cause_o)));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

endmodule

bind tlc_tx_capture tlc_checker #(.DATA_W(DATA_W), .N_ALARM(N_ALARM)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .ais_o        (ais_o),
    .ais_cause_o  (ais_cause_o)
);

// File: tb/tlc_tx_capture_test.sv
`timescale 1ns/1ps
module tlc_tx_capture_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nibble_mode_i = 1'b0;
    logic       cap_on_fall_i = 1'b0;
    logic       line_clk_i = 1'b0;
    logic [7:0] line_data_i = '0;
    logic       force_ais_i = 1'b0;
    logic [2:0] alarm_i = '0;
    logic [2:0] alarm_en_i = '0;
    logic [7:0] word_o;
    logic       word_valid_o;
    logic       ais_o;
    logic [3:0] ais_cause_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tlc_tx_capture uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .nibble_mode_i (nibble_mode_i),
        .cap_on_fall_i (cap_on_fall_i),
        .line_clk_i    (line_clk_i),
        .line_data_i   (line_data_i),
        .force_ais_i   (force_ais_i),
        .alarm_i       (alarm_i),
        .alarm_en_i    (alarm_en_i),
        .word_o        (word_o),
        .word_valid_o  (word_valid_o),
        .ais_o         (ais_o),
        .ais_cause_o   (ais_cause_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one capture edge, then the opposite edge with inverted data
    task automatic capture(input logic [7:0] d, input logic last,
                           input logic [7:0] exp_w, input logic exp_ais,
                           input logic [3:0] exp_cause, input logic nib);
        logic act_lvl;
        logic ais_before;
        act_lvl = ~cap_on_fall_i;
        ais_before = ais_o;
        @(negedge clk);
        line_clk_i  = act_lvl;
        line_data_i = d;
        @(negedge clk);
        if (last) begin
            chk(cap_on_fall_i ? "R2 capture valid" : "R1 capture valid", word_valid_o, 1);
            chk(nib ? "R4 nibble word" : "R3 byte word", word_o, exp_w);
            chk("R10 ais status", ais_o, exp_ais);
            chk("R11 cause", ais_cause_o, exp_cause);
        end else begin
            chk("R4 first nibble emits nothing", word_valid_o, 0);
            chk("R10 status held", ais_o, ais_before);
        end
        line_clk_i  = ~act_lvl;
        line_data_i = ~d;
        @(negedge clk);
        chk(cap_on_fall_i ? "R2 opposite edge ignored" : "R1 opposite edge ignored",
            word_valid_o, 0);
    endtask

    task automatic do_reset(input logic nib, input logic fall);
        @(negedge clk);
        rst_n = 1'b0;
        nibble_mode_i = nib;
        cap_on_fall_i = fall;
        line_clk_i = fall;
        force_ais_i = 1'b0;
        alarm_i = '0;
        alarm_en_i = '0;
        repeat (3) @(negedge clk);
        chk("R12 reset valid", word_valid_o, 0);
        chk("R12 reset word", word_o, 0);
        chk("R12 reset ais", ais_o, 0);
        chk("R12 reset cause", ais_cause_o, 0);
        rst_n = 1'b1;
        // R5: mode pin flipped after reset must not matter
        nibble_mode_i = ~nib;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic nib,
                        input logic [7:0] exp_w, input logic exp_ais, input logic [3:0] exp_c);
        if (nib) begin
            capture({4'h5, b[7:4]}, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1);
            capture({4'hA, b[3:0]}, 1'b1, exp_w, exp_ais, exp_c, 1'b1);
        end else begin
            capture(b, 1'b1, exp_w, exp_ais, exp_c, 1'b0);
        end
    endtask

    initial begin
        #500000ns;
        n_bad++;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int cfg = 0; cfg < 4; cfg++) begin
            logic nib, fall;
            nib  = cfg[1];
            fall = cfg[0];
            do_reset(nib, fall);
            for (int c = 0; c < 128; c++) begin
                logic [7:0] b, ew;
                logic [3:0] ec;
                logic       ea;
                b = 8'((c * 37 + cfg * 11 + 3) & 8'hFF);
                @(negedge clk);
                force_ais_i = c[0];
                alarm_i     = c[3:1];
                alarm_en_i  = c[6:4];
                ec = {c[3] & c[6], c[2] & c[5], c[1] & c[4], c[0]};
                ea = |ec;
                ew = ea ? 8'hFF : b;
                @(negedge clk);
                // R6 R7 R8 R9 all covered by this gated OR sweep
                send(b, nib, ew, ea, ec);
            end
            // R10: status holds between bytes, then follows the next byte
            @(negedge clk);
            force_ais_i = 1'b0;
            alarm_i = '0;
            alarm_en_i = '0;
            repeat (3) @(negedge clk);
            chk("R10 ais holds without byte", ais_o, 1);
            chk("R10 cause holds without byte", ais_cause_o, 4'hF);
            send(8'h3C, nib, 8'h3C, 1'b0, 4'h0);
            // R10: alarm raised one cycle before capture takes effect
            @(negedge clk);
            force_ais_i = 1'b1;
            send(8'h81, nib, 8'hFF, 1'b1, 4'h1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule